// File: doc/BRIEF.md
# Mode-Dependent Link Clock Generator

This block produces the local clocks and frame timing for a serial link endpoint. It uses two clocks. A 40.96 MHz master clock gives a half-rate 20.48 MHz system clock and an inverted 4.096 MHz clock that goes back to an external PLL as its feedback. A 20.48 MHz clock extracted from the incoming line feeds a receive divider. That divider is forced back to phase zero whenever the line framer reports frame sync. Its outputs are a recovered 4.096 MHz reference, a 2.048 MHz receive data clock and an 8 kHz frame pulse.

The operating role is latched from three mode pins while power-on reset is held. In controller role the system supplies the 4.096 MHz reference and the 8 kHz frame pulse, and the block passes them on. In peripheral role the block drives both of them onto the system side from the recovered receive timing. Bidirectional system pins appear as separate in, out and output-enable ports.

Top module: `link_clock_gen`

## Requirements
- R1: After power-on reset is released, the system clock output toggles on every master clock edge and starts high on the first edge, so it runs at half the master rate.
- R2: The feedback clock output has a period of 10 master cycles, low for 5 and high for 5. Counting master edges k from reset release, it is high exactly when k mod 10 is 5 or more.
- R3: The receive data clock output has a period of 10 extracted-clock cycles. Counting k from the edge that takes the sync pulse as k = 0, it is high exactly when k mod 10 is below 5.
- R4: The recovered reference has a period of 5 extracted-clock cycles. With the same k, it is high exactly when k mod 5 is below 2.
- R5: A sync-detect pulse sampled on an extracted-clock edge forces that edge to k = 0 whatever the previous phase. After it, reference and data clock are high and the frame pulse is low.
- R6: The mode pins are captured only while power-on reset is low. Pin changes after release leave the latched mode output and the role-dependent routing unchanged.
- R7: Controller role is latched-mode bit 0 = 0. In that role the PLL reference output follows the system reference input, the frame reference output follows the frame pulse input, and both system-side output enables are 0.
- R8: Peripheral role is latched-mode bit 0 = 1. In that role the PLL reference output and the system reference output both carry the recovered reference, and both system-side output enables are 1.
- R9: In peripheral role the frame pulse output is active low for 5 extracted-clock cycles (one reference period) at the start of every 2560-cycle frame (512 reference periods), with the first pulse starting at k = 0. The frame reference output equals it.
- R10: While power-on reset is low, every divider is cleared. System clock, feedback clock, data clock and recovered reference read 0, the frame pulse output reads 1, and the latched mode equals the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | 40.96 MHz master clock from the transmit PLL |
| rx_clk | input | 1 | 20.48 MHz clock extracted from the receive line |
| por_n | input | 1 | Active-low power-on reset, synchronous in both domains |
| mode_pins | input | 3 | Operating mode pins, captured during reset |
| rx_sync_det | input | 1 | Frame-sync detect pulse, rx_clk domain |
| sysref_in | input | 1 | System 4.096 MHz reference (controller role) |
| fp_in | input | 1 | System 8 kHz frame pulse, active low (controller role) |
| sys_clk_o | output | 1 | 20.48 MHz system clock |
| fb_clk_n_o | output | 1 | Inverted 4.096 MHz PLL feedback clock |
| pll_ref_o | output | 1 | 4.096 MHz reference to the transmit PLL |
| sysref_o | output | 1 | Recovered reference driven to the system pin |
| sysref_oe | output | 1 | Output enable for the system reference pin |
| rx_data_clk_o | output | 1 | 2.048 MHz receive data clock |
| fp_o | output | 1 | Generated 8 kHz frame pulse, active low |
| fp_oe | output | 1 | Output enable for the frame pulse pin |
| frame_ref_n_o | output | 1 | Frame pulse in use for the current role, active low |
| mode_o | output | 3 | Latched operating mode |

## Verification
The hardest state to reach is the realignment: a sync pulse that arrives while the receive divider is partway through its reference and data-clock cycles, well away from a wrap. The stimulus lets the divider run three cycles past a multiple of its period and then pulses sync. It checks that the next sample restarts at phase zero rather than carrying on the old count. The frame pulse is only observable over thousands of extracted-clock cycles. Its wrap is therefore checked across two whole frames in peripheral role, including the cycle where the 2560-count rolls over.

// File: rtl/lcg_pkg.sv
package lcg_pkg;

    // Role decoded from the latched mode
    typedef enum logic {
        ROLE_CTRL   = 1'b0,
        ROLE_PERIPH = 1'b1
    } role_e;

endpackage

// File: rtl/lcg_tx_div.sv
module lcg_tx_div #(
    parameter int TX_DIV = 10,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [MODE_W-1:0] mode_pins,
    output logic              sys_clk_o,
    output logic              fb_clk_n_o,
    output logic [MODE_W-1:0] mode_o
);
    localparam int CW   = $clog2(TX_DIV);
    localparam int HALF = TX_DIV / 2;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              sys;
        logic              fb;
        logic [MODE_W-1:0] mode;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d.cnt  = '0;
            st_d.sys  = 1'b0;
            st_d.fb   = 1'b0;
            st_d.mode = mode_pins;      // capture only during reset
        end else begin
            st_d.cnt  = (st_q.cnt == CW'(TX_DIV - 1)) ? '0 : st_q.cnt + 1'b1;
            st_d.sys  = ~st_q.sys;
            // divided clock is high in the first half; output is its inverse
            st_d.fb   = (st_d.cnt >= CW'(HALF));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign sys_clk_o  = st_q.sys;
    assign fb_clk_n_o = st_q.fb;
    assign mode_o     = st_q.mode;

    AST_SYS_TOGGLE: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> (st_q.sys != $past(st_q.sys)));                      // R1
    AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt < CW'(TX_DIV));                                        // R2
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        por_n |=> $stable(st_q.mode));                                  // R6

endmodule

// File: rtl/lcg_rx_div.sv
module lcg_rx_div #(
    parameter int RX_DIV     = 5,
    parameter int FRAME_REFS = 512
) (
    input  logic clk,
    input  logic por_n,
    input  logic sync_det,
    output logic ref_o,
    output logic data_clk_o,
    output logic fp_n_o
);
    localparam int PER    = 2 * RX_DIV;          // data clock = reference / 2
    localparam int CW     = $clog2(PER);
    localparam int REF_HI = RX_DIV / 2;
    localparam int FLEN   = FRAME_REFS * RX_DIV;
    localparam int FW     = $clog2(FLEN);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [FW-1:0] fcnt;
        logic          rf;
        logic          dat;
        logic          fp;
    } rx_st_t;

    rx_st_t        st_d, st_q;
    logic [CW-1:0] sub_d;

    always_comb begin
        st_d = st_q;
        if (!por_n) begin
            st_d.cnt  = '0;
            st_d.fcnt = '0;
        end else if (sync_det) begin
            st_d.cnt  = '0;              // phase correction on frame sync
            st_d.fcnt = '0;
        end else begin
            st_d.cnt  = (st_q.cnt == CW'(PER - 1)) ? '0 : st_q.cnt + 1'b1;
            st_d.fcnt = (st_q.fcnt == FW'(FLEN - 1)) ? '0 : st_q.fcnt + 1'b1;
        end

        sub_d = (st_d.cnt >= CW'(RX_DIV)) ? st_d.cnt - CW'(RX_DIV) : st_d.cnt;

        if (!por_n) begin
            st_d.rf  = 1'b0;
            st_d.dat = 1'b0;
            st_d.fp  = 1'b1;
        end else begin
            st_d.rf  = (sub_d < CW'(REF_HI));
            st_d.dat = (st_d.cnt < CW'(RX_DIV));
            st_d.fp  = !(st_d.fcnt < FW'(RX_DIV));
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ref_o      = st_q.rf;
    assign data_clk_o = st_q.dat;
    assign fp_n_o     = st_q.fp;

    AST_RX_SYNC_ALIGN: assert property (@(posedge clk) disable iff (!por_n)
        sync_det |=> (st_q.rf && st_q.dat && !st_q.fp));                // R5
    AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        st_q.cnt < CW'(PER));                                           // R3
    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        st_q.fcnt < FW'(FLEN));                                         // R9

endmodule

// File: rtl/lcg_role_mux.sv
module lcg_role_mux
    import lcg_pkg::*;
(
    input  logic periph,
    input  logic sysref_in,
    input  logic fp_in,
    input  logic rx_ref,
    input  logic rx_fp_n,
    output logic pll_ref_o,
    output logic sysref_o,
    output logic sysref_oe,
    output logic fp_o,
    output logic fp_oe,
    output logic frame_ref_n_o
);
    role_e role;

    always_comb begin
        role          = role_e'(periph);
        sysref_o      = rx_ref;
        fp_o          = rx_fp_n;
        if (role == ROLE_PERIPH) begin
            pll_ref_o     = rx_ref;
            frame_ref_n_o = rx_fp_n;
            sysref_oe     = 1'b1;
            fp_oe         = 1'b1;
        end else begin
            pll_ref_o     = sysref_in;
            frame_ref_n_o = fp_in;
            sysref_oe     = 1'b0;
            fp_oe         = 1'b0;
        end
    end

endmodule

// File: rtl/link_clock_gen.sv
module link_clock_gen #(
    parameter int TX_DIV     = 10,
    parameter int RX_DIV     = 5,
    parameter int FRAME_REFS = 512,
    parameter int MODE_W     = 3,
    parameter int ROLE_BIT   = 0
) (
    input  logic              mst_clk,
    input  logic              rx_clk,
    input  logic              por_n,
    input  logic [MODE_W-1:0] mode_pins,
    input  logic              rx_sync_det,
    input  logic              sysref_in,
    input  logic              fp_in,
    output logic              sys_clk_o,
    output logic              fb_clk_n_o,
    output logic              pll_ref_o,
    output logic              sysref_o,
    output logic              sysref_oe,
    output logic              rx_data_clk_o,
    output logic              fp_o,
    output logic              fp_oe,
    output logic              frame_ref_n_o,
    output logic [MODE_W-1:0] mode_o
);
    logic rx_ref;
    logic rx_fp_n;

    lcg_tx_div #(
        .TX_DIV (TX_DIV),
        .MODE_W (MODE_W)
    ) u_tx (
        .clk        (mst_clk),
        .por_n      (por_n),
        .mode_pins  (mode_pins),
        .sys_clk_o  (sys_clk_o),
        .fb_clk_n_o (fb_clk_n_o),
        .mode_o     (mode_o)
    );

    lcg_rx_div #(
        .RX_DIV     (RX_DIV),
        .FRAME_REFS (FRAME_REFS)
    ) u_rx (
        .clk        (rx_clk),
        .por_n      (por_n),
        .sync_det   (rx_sync_det),
        .ref_o      (rx_ref),
        .data_clk_o (rx_data_clk_o),
        .fp_n_o     (rx_fp_n)
    );

    lcg_role_mux u_mux (
        .periph        (mode_o[ROLE_BIT]),
        .sysref_in     (sysref_in),
        .fp_in         (fp_in),
        .rx_ref        (rx_ref),
        .rx_fp_n       (rx_fp_n),
        .pll_ref_o     (pll_ref_o),
        .sysref_o      (sysref_o),
        .sysref_oe     (sysref_oe),
        .fp_o          (fp_o),
        .fp_oe         (fp_oe),
        .frame_ref_n_o (frame_ref_n_o)
    );

endmodule

// File: tb/link_clock_gen_test.sv
module link_clock_gen_test;
    logic       mst_clk = 1'b0;
    logic       rx_clk  = 1'b0;
    logic       por_n;
    logic [2:0] mode_pins;
    logic       rx_sync_det;
    logic       sysref_in;
    logic       fp_in;
    logic       sys_clk_o, fb_clk_n_o, pll_ref_o, sysref_o, sysref_oe;
    logic       rx_data_clk_o, fp_o, fp_oe, frame_ref_n_o;
    logic [2:0] mode_o;

    int n_run  = 0;
    int n_fail = 0;

    always #10 mst_clk = ~mst_clk;   // 50 MHz
    always #15 rx_clk  = ~rx_clk;

    link_clock_gen uut (
        .mst_clk       (mst_clk),
        .rx_clk        (rx_clk),
        .por_n         (por_n),
        .mode_pins     (mode_pins),
        .rx_sync_det   (rx_sync_det),
        .sysref_in     (sysref_in),
        .fp_in         (fp_in),
        .sys_clk_o     (sys_clk_o),
        .fb_clk_n_o    (fb_clk_n_o),
        .pll_ref_o     (pll_ref_o),
        .sysref_o      (sysref_o),
        .sysref_oe     (sysref_oe),
        .rx_data_clk_o (rx_data_clk_o),
        .fp_o          (fp_o),
        .fp_oe         (fp_oe),
        .frame_ref_n_o (frame_ref_n_o),
        .mode_o        (mode_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // hold reset, check cleared state (R10), then release at a master negedge
    task automatic t_reset(input logic [2:0] m);
        por_n       = 1'b0;
        mode_pins   = m;
        rx_sync_det = 1'b0;
        repeat (4) @(posedge mst_clk);
        repeat (3) @(posedge rx_clk);
        @(negedge mst_clk);
        chk("R10", "sys clk in reset", 32'(sys_clk_o), 0);
        chk("R10", "fb clk in reset", 32'(fb_clk_n_o), 0);
        chk("R10", "latched mode", 32'(mode_o), 32'(m));
        @(negedge rx_clk);
        chk("R10", "data clk in reset", 32'(rx_data_clk_o), 0);
        chk("R10", "recovered ref in reset", 32'(sysref_o), 0);
        chk("R10", "frame pulse in reset", 32'(fp_o), 1);
    endtask

    task automatic t_tx_divs();
        @(negedge mst_clk);
        por_n = 1'b1;
        for (int k = 1; k <= 40; k++) begin
            @(negedge mst_clk);
            chk("R1", "system clock", 32'(sys_clk_o), 32'(k % 2));
            chk("R2", "feedback clock", 32'(fb_clk_n_o), 32'((k % 10) >= 5));
        end
    endtask

    task automatic pulse_sync();
        @(negedge rx_clk);
        rx_sync_det = 1'b1;
        @(negedge rx_clk);
        rx_sync_det = 1'b0;
    endtask

    task automatic check_rx(input int k);
        chk("R3", "data clock", 32'(rx_data_clk_o), 32'((k % 10) < 5));
        chk("R4", "recovered ref", 32'(sysref_o), 32'((k % 5) < 2));
    endtask

    task automatic t_rx_align();
        pulse_sync();
        for (int k = 0; k < 30; k++) begin
            if (k > 0) @(negedge rx_clk);
            check_rx(k);
        end
    endtask

    task automatic t_realign();
        repeat (3) @(negedge rx_clk);   // leave the divider mid-phase
        pulse_sync();
        chk("R5", "ref after realign", 32'(sysref_o), 1);
        chk("R5", "data after realign", 32'(rx_data_clk_o), 1);
        for (int k = 1; k < 8; k++) begin
            @(negedge rx_clk);
            check_rx(k);
        end
    endtask

    task automatic t_controller();
        sysref_in = 1'b1; #1;
        chk("R7", "pll ref follows system ref high", 32'(pll_ref_o), 1);
        sysref_in = 1'b0; #1;
        chk("R7", "pll ref follows system ref low", 32'(pll_ref_o), 0);
        fp_in = 1'b0; #1;
        chk("R7", "frame ref follows input low", 32'(frame_ref_n_o), 0);
        fp_in = 1'b1; #1;
        chk("R7", "frame ref follows input high", 32'(frame_ref_n_o), 1);
        chk("R7", "system ref enable", 32'(sysref_oe), 0);
        chk("R7", "frame pulse enable", 32'(fp_oe), 0);
    endtask

    task automatic t_mode_ignore();
        mode_pins = 3'b001;
        repeat (5) @(posedge mst_clk);
        @(negedge mst_clk);
        chk("R6", "latched mode unchanged", 32'(mode_o), 32'(3'b110));
        chk("R6", "system ref enable unchanged", 32'(sysref_oe), 0);
        sysref_in = 1'b1; #1;
        chk("R6", "pll ref still from system", 32'(pll_ref_o), 1);
        sysref_in = 1'b0; #1;
        chk("R6", "pll ref still from system", 32'(pll_ref_o), 0);
    endtask

    task automatic t_periph();
        @(negedge mst_clk);
        por_n = 1'b1;
        fp_in = 1'b0;        // must not reach the frame reference
        chk("R8", "system ref enable", 32'(sysref_oe), 1);
        chk("R8", "frame pulse enable", 32'(fp_oe), 1);
        pulse_sync();
        for (int k = 0; k < 5200; k++) begin
            if (k > 0) @(negedge rx_clk);
            chk("R9", "frame pulse", 32'(fp_o), 32'(!((k % 2560) < 5)));
            chk("R9", "frame ref", 32'(frame_ref_n_o), 32'(!((k % 2560) < 5)));
            chk("R8", "pll ref", 32'(pll_ref_o), 32'((k % 5) < 2));
            chk("R8", "system ref out", 32'(sysref_o), 32'((k % 5) < 2));
        end
    endtask

    initial begin
        por_n       = 1'b0;
        mode_pins   = 3'b110;
        rx_sync_det = 1'b0;
        sysref_in   = 1'b0;
        fp_in       = 1'b1;
        t_reset(3'b110);
        t_tx_divs();
        t_rx_align();
        t_realign();
        t_controller();
        t_mode_ignore();
        t_reset(3'b101);
        t_periph();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule